// File: doc/BRIEF.md
# Burst-Granular Producer-Consumer Read Gate

This block sits beside a shared frame buffer. A capture engine writes into the buffer, and a compression engine reads from it while the frame is still being filled. The block watches the writer's write-address and write-response channels. It keeps a watermark, which is the byte offset from the buffer base up to which data is known to be in memory. The writer fills the buffer in raster order, so everything below the watermark is valid. The watermark moves forward one burst at a time, and only when a burst's write response comes back without error.

The reader's read-address requests pass through a one-entry holding stage. A request that lies inside the buffer window goes out to memory only when its last byte is below the watermark. Until then it waits, and no other read is accepted. Requests outside the window are not gated. The block also divides the frame into 8 or 16 horizontal slices and emits a pulse each time the watermark crosses a slice boundary. It raises a flag once the whole buffer has been written.

The write-address payload goes from writer to memory directly; only its valid/ready pair passes through the block. A frame-start strobe begins a new frame. Write responses for bursts issued before that strobe are then disregarded.

Top module: `burst_read_gate`

## Requirements
- R1: After reset the watermark is 0, the frame-complete flag is low, the slice pulse is low, the read stage is empty (reader-side ready high, memory-side valid low), and the write-address ready follows the memory's ready.
- R2: The block records each accepted write burst's end offset: (address − base) + (len+1)·2^size bytes. The watermark takes that value when the matching write response arrives with response code 2'b00. Responses match bursts in issue order. Address acceptance alone never moves the watermark.
- R3: A write response with any code other than 2'b00 retires its burst and leaves the watermark unchanged.
- R4: A held read whose start address lies in [base, base+size) is presented to memory only when its end offset, (address − base) + (len+1)·2^size, is at most the watermark. Until then memory-side read valid stays low.
- R5: A read whose start address lies outside [base, base+size) is presented to memory in the cycle after it is taken, whatever the watermark.
- R6: One read is held at a time. The reader-side ready is low from the cycle after a read is taken until memory accepts it. The held address, length and size stay unchanged until then.
- R7: The block tracks at most FIFO_DEPTH bursts awaiting their response. While that many are outstanding, the writer-side ready and the memory-side write-address valid are both low.
- R8: A frame-start pulse clears the watermark, the frame-complete flag and the slice progress. A response to a burst issued before the pulse does not move the watermark. A held read stays held until new writes cover it.
- R9: The slice pulse is high for one cycle for each boundary k·(size/N) the watermark reaches, with N = 8 when the slice-count select is 0 and N = 16 when it is 1. There is at most one pulse per cycle and at most N per frame.
- R10: Once the watermark reaches the buffer size, the frame-complete flag is set one cycle later. From then on, every in-window read is presented regardless of its end offset, until the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgBase | input | ADDR_W | Buffer base address |
| cfgSize | input | ADDR_W | Buffer size in bytes |
| cfgSlices16 | input | 1 | Slice count select: 0 = 8, 1 = 16 |
| frameStart | input | 1 | One-cycle new-frame strobe |
| awValidIn | input | 1 | Writer write-address valid |
| awReadyOut | output | 1 | Write-address ready to writer |
| awAddr | input | ADDR_W | Writer burst address |
| awLen | input | LEN_W | Writer burst length minus one |
| awSize | input | SIZE_W | Writer beat size, log2 bytes |
| awValidOut | output | 1 | Write-address valid to memory |
| awReadyIn | input | 1 | Write-address ready from memory |
| bValid | input | 1 | Write-response valid (observed) |
| bReady | input | 1 | Write-response ready (observed) |
| bResp | input | 2 | Write-response code (observed) |
| arValidIn | input | 1 | Reader read-address valid |
| arReadyOut | output | 1 | Read-address ready to reader |
| arAddrIn | input | ADDR_W | Reader burst address |
| arLenIn | input | LEN_W | Reader burst length minus one |
| arSizeIn | input | SIZE_W | Reader beat size, log2 bytes |
| arValidOut | output | 1 | Read-address valid to memory |
| arReadyIn | input | 1 | Read-address ready from memory |
| arAddrOut | output | ADDR_W | Held read address to memory |
| arLenOut | output | LEN_W | Held read length to memory |
| arSizeOut | output | SIZE_W | Held read size to memory |
| watermark | output | ADDR_W | Committed byte offset from base |
| slicePulse | output | 1 | Slice boundary crossed |
| frameDone | output | 1 | Whole buffer committed |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, 8-bit lengths, 3-bit sizes and a four-entry response-tracking queue. The queue is shallow enough that four back-to-back bursts reach the full condition, so the write-address backpressure can be checked directly. The buffer is configured as 1 KiB, which makes 128- and 64-byte slices. A few large bursts therefore cross several slice boundaries in one response, which exercises the one-pulse-per-cycle path and the per-frame pulse limit for both slice counts. A read that runs past the end of the window can only be released by the frame-complete override.

// File: rtl/rg_pkg.sv
package rg_pkg;

  localparam logic [1:0] RESP_OKAY = 2'b00;

  typedef struct packed {
    logic push;
    logic pop;
    logic wmUpdate;
    logic frameClear;
    logic slotLoad;
    logic slotClear;
    logic sliceStep;
  } gateStrobes_t;

  typedef struct packed {
    logic headCurrent;
    logic slotAllowed;
    logic crossBoundary;
    logic wmFull;
  } gateStatus_t;

endpackage

// File: rtl/burst_read_gate_dp.sv
module burst_read_gate_dp
  import rg_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 8,
  parameter int SIZE_W     = 3,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  gateStrobes_t      strobes,
  input  logic              curEpoch,
  input  logic              frameDone,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [ADDR_W-1:0] cfgSize,
  input  logic              cfgSlices16,
  input  logic [ADDR_W-1:0] awAddr,
  input  logic [LEN_W-1:0]  awLen,
  input  logic [SIZE_W-1:0] awSize,
  input  logic [ADDR_W-1:0] arAddrIn,
  input  logic [LEN_W-1:0]  arLenIn,
  input  logic [SIZE_W-1:0] arSizeIn,
  output logic [ADDR_W-1:0] arAddrOut,
  output logic [LEN_W-1:0]  arLenOut,
  output logic [SIZE_W-1:0] arSizeOut,
  output logic [ADDR_W-1:0] watermark,
  output gateStatus_t       status
);

  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(FIFO_DEPTH - 1);

  function automatic logic [ADDR_W-1:0] burstBytes(input logic [LEN_W-1:0] len,
                                                   input logic [SIZE_W-1:0] sz);
    return (ADDR_W'(len) + ADDR_W'(1)) << sz;
  endfunction

  function automatic logic inWindow(input logic [ADDR_W-1:0] addr,
                                    input logic [ADDR_W-1:0] base,
                                    input logic [ADDR_W-1:0] size);
    return (addr >= base) && ((addr - base) < size);
  endfunction

  // Outstanding-burst queue: end offset, window flag, frame epoch
  logic [ADDR_W-1:0] fifoEnd   [FIFO_DEPTH];
  logic              fifoWin   [FIFO_DEPTH];
  logic              fifoEpoch [FIFO_DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;

  always_ff @(posedge clk) begin
    if (strobes.push) begin
      fifoEnd[wrPtr]   <= (awAddr - cfgBase) + burstBytes(awLen, awSize);
      fifoWin[wrPtr]   <= inWindow(awAddr, cfgBase, cfgSize);
      fifoEpoch[wrPtr] <= curEpoch ^ strobes.frameClear;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobes.push) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + PTR_W'(1);
      if (strobes.pop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + PTR_W'(1);
    end
  end

  // Watermark and next slice boundary
  logic [ADDR_W-1:0] boundary;
  logic [ADDR_W-1:0] sliceBytes;
  logic [ADDR_W-1:0] headEnd;

  assign sliceBytes = cfgSlices16 ? (cfgSize >> 4) : (cfgSize >> 3);
  assign headEnd    = fifoEnd[rdPtr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      watermark <= '0;
      boundary  <= '1;
    end else begin
      if (strobes.frameClear) begin
        watermark <= '0;
        boundary  <= sliceBytes;
      end else begin
        if (strobes.wmUpdate && (headEnd > watermark)) watermark <= headEnd;
        if (strobes.sliceStep) boundary <= boundary + sliceBytes;
      end
    end
  end

  // Single held read
  logic [ADDR_W-1:0] slotEnd;
  logic              slotInWin;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      arAddrOut <= '0;
      arLenOut  <= '0;
      arSizeOut <= '0;
      slotEnd   <= '0;
      slotInWin <= 1'b0;
    end else if (strobes.slotLoad) begin
      arAddrOut <= arAddrIn;
      arLenOut  <= arLenIn;
      arSizeOut <= arSizeIn;
      slotEnd   <= (arAddrIn - cfgBase) + burstBytes(arLenIn, arSizeIn);
      slotInWin <= inWindow(arAddrIn, cfgBase, cfgSize);
    end
  end

  always_comb begin
    status.headCurrent   = fifoWin[rdPtr] && (fifoEpoch[rdPtr] == curEpoch);
    status.slotAllowed   = !slotInWin || frameDone || (slotEnd <= watermark);
    status.crossBoundary = watermark >= boundary;
    status.wmFull        = (cfgSize != '0) && (watermark >= cfgSize);
  end

endmodule

// File: rtl/burst_read_gate_ctrl.sv
module burst_read_gate_ctrl
  import rg_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         cfgSlices16,
  input  logic         frameStart,
  input  logic         awValidIn,
  input  logic         awReadyIn,
  input  logic         bValid,
  input  logic         bReady,
  input  logic [1:0]   bResp,
  input  logic         arValidIn,
  input  logic         arReadyIn,
  input  gateStatus_t  status,
  output gateStrobes_t strobes,
  output logic         curEpoch,
  output logic         awReadyOut,
  output logic         awValidOut,
  output logic         arReadyOut,
  output logic         arValidOut,
  output logic         slicePulse,
  output logic         frameDone
);

  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FIFO_DEPTH);

  logic [CNT_W-1:0] count;
  logic             slotValid;
  logic [4:0]       sliceCount;
  logic [4:0]       sliceTotal;
  logic             fifoFull;

  assign fifoFull   = (count == FULL_CNT);
  assign sliceTotal = cfgSlices16 ? 5'd16 : 5'd8;

  always_comb begin
    strobes.frameClear = frameStart;
    strobes.push       = awValidIn && awReadyIn && !fifoFull;
    strobes.pop        = bValid && bReady && (count != '0);
    strobes.wmUpdate   = strobes.pop && (bResp == RESP_OKAY) && status.headCurrent && !frameStart;
    strobes.slotLoad   = arValidIn && !slotValid;
    strobes.slotClear  = slotValid && status.slotAllowed && arReadyIn;
    strobes.sliceStep  = !frameStart && (sliceCount != sliceTotal) && status.crossBoundary;
  end

  assign awReadyOut = awReadyIn && !fifoFull;
  assign awValidOut = awValidIn && !fifoFull;
  assign arReadyOut = !slotValid;
  assign arValidOut = slotValid && status.slotAllowed;
  assign slicePulse = strobes.sliceStep;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count      <= '0;
      slotValid  <= 1'b0;
      sliceCount <= '0;
      frameDone  <= 1'b0;
      curEpoch   <= 1'b0;
    end else begin
      case ({strobes.push, strobes.pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase

      if (strobes.slotLoad)       slotValid <= 1'b1;
      else if (strobes.slotClear) slotValid <= 1'b0;

      if (frameStart) begin
        sliceCount <= '0;
        frameDone  <= 1'b0;
        curEpoch   <= !curEpoch;
      end else begin
        if (strobes.sliceStep) sliceCount <= sliceCount + 5'd1;
        if (status.wmFull)     frameDone  <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/burst_read_gate.sv
module burst_read_gate
  import rg_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 8,
  parameter int SIZE_W     = 3,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [ADDR_W-1:0] cfgSize,
  input  logic              cfgSlices16,
  input  logic              frameStart,
  input  logic              awValidIn,
  output logic              awReadyOut,
  input  logic [ADDR_W-1:0] awAddr,
  input  logic [LEN_W-1:0]  awLen,
  input  logic [SIZE_W-1:0] awSize,
  output logic              awValidOut,
  input  logic              awReadyIn,
  input  logic              bValid,
  input  logic              bReady,
  input  logic [1:0]        bResp,
  input  logic              arValidIn,
  output logic              arReadyOut,
  input  logic [ADDR_W-1:0] arAddrIn,
  input  logic [LEN_W-1:0]  arLenIn,
  input  logic [SIZE_W-1:0] arSizeIn,
  output logic              arValidOut,
  input  logic              arReadyIn,
  output logic [ADDR_W-1:0] arAddrOut,
  output logic [LEN_W-1:0]  arLenOut,
  output logic [SIZE_W-1:0] arSizeOut,
  output logic [ADDR_W-1:0] watermark,
  output logic              slicePulse,
  output logic              frameDone
);

  gateStrobes_t strobes;
  gateStatus_t  status;
  logic         curEpoch;

  burst_read_gate_ctrl #(.FIFO_DEPTH(FIFO_DEPTH)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgSlices16(cfgSlices16),
    .frameStart (frameStart),
    .awValidIn  (awValidIn),
    .awReadyIn  (awReadyIn),
    .bValid     (bValid),
    .bReady     (bReady),
    .bResp      (bResp),
    .arValidIn  (arValidIn),
    .arReadyIn  (arReadyIn),
    .status     (status),
    .strobes    (strobes),
    .curEpoch   (curEpoch),
    .awReadyOut (awReadyOut),
    .awValidOut (awValidOut),
    .arReadyOut (arReadyOut),
    .arValidOut (arValidOut),
    .slicePulse (slicePulse),
    .frameDone  (frameDone)
  );

  burst_read_gate_dp #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W), .FIFO_DEPTH(FIFO_DEPTH)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .curEpoch   (curEpoch),
    .frameDone  (frameDone),
    .cfgBase    (cfgBase),
    .cfgSize    (cfgSize),
    .cfgSlices16(cfgSlices16),
    .awAddr     (awAddr),
    .awLen      (awLen),
    .awSize     (awSize),
    .arAddrIn   (arAddrIn),
    .arLenIn    (arLenIn),
    .arSizeIn   (arSizeIn),
    .arAddrOut  (arAddrOut),
    .arLenOut   (arLenOut),
    .arSizeOut  (arSizeOut),
    .watermark  (watermark),
    .status     (status)
  );

endmodule

// File: rtl/burst_read_gate_chk.sv
module burst_read_gate_chk #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8,
  parameter int SIZE_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] cfgBase,
  input logic [ADDR_W-1:0] cfgSize,
  input logic              frameStart,
  input logic              awReadyIn,
  input logic              awReadyOut,
  input logic              awValidOut,
  input logic              arValidIn,
  input logic              arReadyOut,
  input logic              arValidOut,
  input logic              arReadyIn,
  input logic [ADDR_W-1:0] arAddrOut,
  input logic [LEN_W-1:0]  arLenOut,
  input logic [SIZE_W-1:0] arSizeOut,
  input logic [ADDR_W-1:0] watermark,
  input logic              frameDone
);

  logic [ADDR_W-1:0] reqEnd;
  logic              reqInWin;
  assign reqEnd   = (arAddrOut - cfgBase) + ((ADDR_W'(arLenOut) + ADDR_W'(1)) << arSizeOut);
  assign reqInWin = (arAddrOut >= cfgBase) && ((arAddrOut - cfgBase) < cfgSize);

  // R2: watermark only moves forward within a frame
  a_r2_monotone: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |=> watermark >= $past(watermark));

  // R4: an in-window read reaches memory only when covered
  a_r4_forward_covered: assert property (@(posedge clk) disable iff (!rstN)
    arValidOut && reqInWin && !frameDone |-> reqEnd <= watermark);

  // R6: taking a read closes the reader-side ready
  a_r6_single_slot: assert property (@(posedge clk) disable iff (!rstN)
    arValidIn && arReadyOut |=> !arReadyOut);

  // R6: presented read is held steady until accepted
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    arValidOut && !arReadyIn |=> $stable(arAddrOut) && $stable(arLenOut) && $stable(arSizeOut));

  // R7: a full queue blocks the write-address handshake
  a_r7_full_blocks: assert property (@(posedge clk) disable iff (!rstN)
    awReadyIn && !awReadyOut |-> !awValidOut);

  // R8: frame start clears progress
  a_r8_frame_clear: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> watermark == '0 && !frameDone);

endmodule

bind burst_read_gate burst_read_gate_chk #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cfgBase   (cfgBase),
  .cfgSize   (cfgSize),
  .frameStart(frameStart),
  .awReadyIn (awReadyIn),
  .awReadyOut(awReadyOut),
  .awValidOut(awValidOut),
  .arValidIn (arValidIn),
  .arReadyOut(arReadyOut),
  .arValidOut(arValidOut),
  .arReadyIn (arReadyIn),
  .arAddrOut (arAddrOut),
  .arLenOut  (arLenOut),
  .arSizeOut (arSizeOut),
  .watermark (watermark),
  .frameDone (frameDone)
);

// File: tb/burst_read_gate_bench.sv
module burst_read_gate_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] cfgBase = 32'h1000;
  logic [31:0] cfgSize = 32'h400;
  logic        cfgSlices16 = 1'b0;
  logic        frameStart = 1'b0;
  logic        awValidIn = 1'b0;
  logic [31:0] awAddr = '0;
  logic [7:0]  awLen = '0;
  logic [2:0]  awSize = '0;
  logic        awReadyIn = 1'b1;
  logic        bValid = 1'b0;
  logic        bReady = 1'b1;
  logic [1:0]  bResp = 2'b00;
  logic        arValidIn = 1'b0;
  logic [31:0] arAddrIn = '0;
  logic [7:0]  arLenIn = '0;
  logic [2:0]  arSizeIn = '0;
  logic        arReadyIn = 1'b1;
  logic        awReadyOut, awValidOut, arReadyOut, arValidOut, slicePulse, frameDone;
  logic [31:0] arAddrOut, watermark;
  logic [7:0]  arLenOut;
  logic [2:0]  arSizeOut;

  int checks = 0;
  int fails = 0;
  int pulseCount = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  burst_read_gate u_burst_read_gate (
    .clk(clk), .rstN(rstN), .cfgBase(cfgBase), .cfgSize(cfgSize),
    .cfgSlices16(cfgSlices16), .frameStart(frameStart),
    .awValidIn(awValidIn), .awReadyOut(awReadyOut), .awAddr(awAddr),
    .awLen(awLen), .awSize(awSize), .awValidOut(awValidOut), .awReadyIn(awReadyIn),
    .bValid(bValid), .bReady(bReady), .bResp(bResp),
    .arValidIn(arValidIn), .arReadyOut(arReadyOut), .arAddrIn(arAddrIn),
    .arLenIn(arLenIn), .arSizeIn(arSizeIn), .arValidOut(arValidOut),
    .arReadyIn(arReadyIn), .arAddrOut(arAddrOut), .arLenOut(arLenOut),
    .arSizeOut(arSizeOut), .watermark(watermark), .slicePulse(slicePulse),
    .frameDone(frameDone)
  );

  always @(negedge clk) if (rstN && slicePulse) pulseCount++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendAw(input logic [31:0] a, input logic [7:0] l, input logic [2:0] s);
    awValidIn = 1'b1; awAddr = a; awLen = l; awSize = s;
    tick();
    awValidIn = 1'b0;
  endtask

  task automatic sendB(input logic [1:0] r);
    bValid = 1'b1; bResp = r;
    tick();
    bValid = 1'b0; bResp = 2'b00;
  endtask

  task automatic newFrame(input logic s16);
    cfgSlices16 = s16; frameStart = 1'b1;
    tick();
    frameStart = 1'b0;
  endtask

  task automatic offerRead(input logic [31:0] a, input logic [7:0] l, input logic [2:0] s);
    arValidIn = 1'b1; arAddrIn = a; arLenIn = l; arSizeIn = s;
    tick();
    arValidIn = 1'b0;
  endtask

  task automatic testReset;
    check("R1 watermark", watermark, 0);
    check("R1 frameDone", {31'd0, frameDone}, 0);
    check("R1 slicePulse", {31'd0, slicePulse}, 0);
    check("R1 arReadyOut", {31'd0, arReadyOut}, 1);
    check("R1 arValidOut", {31'd0, arValidOut}, 0);
    check("R1 awReadyOut", {31'd0, awReadyOut}, 1);
  endtask

  task automatic testCommit;
    newFrame(1'b0);
    sendAw(32'h1000, 8'd3, 3'd2);
    tick(2);
    check("R2 no advance on address", watermark, 0);
    sendB(2'b00);
    check("R2 first response", watermark, 16);
    sendAw(32'h1010, 8'd3, 3'd2);
    sendAw(32'h1020, 8'd3, 3'd2);
    sendB(2'b00);
    check("R2 in-order second", watermark, 32);
    sendB(2'b00);
    check("R2 in-order third", watermark, 48);
  endtask

  task automatic testErrorResp;
    sendAw(32'h1030, 8'd3, 3'd2);
    sendB(2'b10);
    check("R3 error ignored", watermark, 48);
    sendAw(32'h1030, 8'd3, 3'd2);
    sendB(2'b00);
    check("R3 retry commits", watermark, 64);
  endtask

  task automatic testGatedRead;
    offerRead(32'h1040, 8'd1, 3'd3);
    check("R4 uncovered read stalled", {31'd0, arValidOut}, 0);
    check("R6 ready low while held", {31'd0, arReadyOut}, 0);
    offerRead(32'h1200, 8'd0, 3'd0);
    check("R6 held address kept", arAddrOut, 32'h1040);
    arReadyIn = 1'b0;
    sendAw(32'h1040, 8'd3, 3'd2);
    sendB(2'b00);
    check("R4 covered read presented", {31'd0, arValidOut}, 1);
    tick();
    check("R6 held while memory busy", {31'd0, arValidOut}, 1);
    check("R6 address stable", arAddrOut, 32'h1040);
    check("R6 length stable", {24'd0, arLenOut}, 1);
    arReadyIn = 1'b1;
    tick();
    check("R6 slot freed", {31'd0, arReadyOut}, 1);
    check("R6 no valid after accept", {31'd0, arValidOut}, 0);
  endtask

  task automatic testBypass;
    offerRead(32'h0800, 8'd7, 3'd3);
    check("R5 below window passes", {31'd0, arValidOut}, 1);
    tick();
    offerRead(32'h2000, 8'd7, 3'd3);
    check("R5 above window passes", {31'd0, arValidOut}, 1);
    tick();
  endtask

  task automatic testBackpressure;
    newFrame(1'b0);
    for (int i = 0; i < 4; i++) sendAw(32'h1000 + 32'(i * 16), 8'd3, 3'd2);
    awValidIn = 1'b1; awAddr = 32'h1040;
    #1;
    check("R7 ready low when full", {31'd0, awReadyOut}, 0);
    check("R7 valid low when full", {31'd0, awValidOut}, 0);
    awValidIn = 1'b0;
    sendB(2'b00);
    check("R7 ready back after response", {31'd0, awReadyOut}, 1);
    for (int i = 0; i < 3; i++) sendB(2'b00);
    check("R7 drained watermark", watermark, 64);
  endtask

  task automatic testFrameStart;
    offerRead(32'h1040, 8'd1, 3'd3);
    sendAw(32'h1040, 8'd3, 3'd2);
    newFrame(1'b0);
    check("R8 watermark cleared", watermark, 0);
    check("R8 frameDone cleared", {31'd0, frameDone}, 0);
    sendB(2'b00);
    check("R8 stale response ignored", watermark, 0);
    check("R8 pending read still held", {31'd0, arValidOut}, 0);
    sendAw(32'h1000, 8'd15, 3'd2);
    sendB(2'b00);
    check("R8 new frame progress", watermark, 64);
    check("R8 read still short", {31'd0, arValidOut}, 0);
    sendAw(32'h1040, 8'd3, 3'd2);
    sendB(2'b00);
    check("R8 read released", {31'd0, arValidOut}, 1);
    tick();
  endtask

  task automatic testSlices;
    newFrame(1'b0);
    pulseCount = 0;
    sendAw(32'h1000, 8'd31, 3'd3);
    sendB(2'b00);
    tick(4);
    check("R9 eight slices two crossed", 32'(pulseCount), 2);
    newFrame(1'b1);
    pulseCount = 0;
    sendAw(32'h1000, 8'd31, 3'd3);
    sendB(2'b00);
    tick(6);
    check("R9 sixteen slices four crossed", 32'(pulseCount), 4);
    sendAw(32'h1100, 8'd95, 3'd3);
    sendB(2'b00);
    tick(20);
    check("R9 full frame sixteen pulses", 32'(pulseCount), 16);
    check("R10 frame complete", {31'd0, frameDone}, 1);
  endtask

  task automatic testFrameDone;
    offerRead(32'h13F0, 8'd7, 3'd3);
    check("R10 overrun read passes when done", {31'd0, arValidOut}, 1);
    tick();
    newFrame(1'b0);
    offerRead(32'h13F0, 8'd7, 3'd3);
    check("R10 overrun read stalls before done", {31'd0, arValidOut}, 0);
    sendAw(32'h1000, 8'd127, 3'd3);
    sendB(2'b00);
    check("R10 watermark at size", watermark, 32'h400);
    check("R10 flag one cycle later", {31'd0, frameDone}, 0);
    tick();
    check("R10 flag set", {31'd0, frameDone}, 1);
    check("R10 overrun read released", {31'd0, arValidOut}, 1);
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick();
    testReset();
    testCommit();
    testErrorResp();
    testGatedRead();
    testBypass();
    testBackpressure();
    testFrameStart();
    testSlices();
    testFrameDone();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule